// File: doc/BRIEF.md
# Peripheral register write-protection controller

This block holds one 32-bit control word that decides which of sixteen protected configuration registers elsewhere in the chip may be written. Each protected target has two controls. The first is a write-enable bit that software may set or clear. The second is a lock bit that software may set but never clear. Once a lock bit is set, its target and its paired enable bit stay frozen until the next reset.

The control word sits on a simple register bus made of an address, a write strobe, write data and combinational read data. Each target sends its own write request into the block. The block passes that request on as a qualified write strobe only when the target's enable bit is 1 and its lock bit is 0. A request that fails this test is dropped without any report. A status vector shows, for each target, whether a write would pass right now.

Top module: `wr_protect_ctrl`

## Requirements
- R1: After reset the control word reads 0xFFFF_0000. The enable bits are bits 31:16 and all of them reset to 1. The lock bits are bits 15:0 and all of them reset to 0.
- R2: When bus_addr equals the control offset 0x1E80, bus_rdata returns the current control word in the same cycle. At any other address it returns 0. A read never changes state.
- R3: On a control write, each lock bit n becomes its old value OR bus_wdata[n]. Writing 0 to a lock bit that is already set leaves it at 1. Only reset clears a lock bit.
- R4: On a control write, enable bit n+16 takes bus_wdata[n+16] when lock bit n was 0 before that write. When lock bit n was already 1, enable bit n+16 keeps its old value.
- R5: tgt_wr_ok[n] equals tgt_wr_req[n] AND enable n AND NOT lock n, in the same cycle as the request.
- R6: tgt_allow[n] equals enable n AND NOT lock n at all times.
- R7: The control word does not change when bus_we is 0, or when bus_we is 1 at an address other than 0x1E80.
- R8: A control write becomes visible on bus_rdata, tgt_allow and tgt_wr_ok right after the rising clock edge that samples bus_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational) |
| tgt_wr_req | input | 16 | Per-target write request |
| tgt_wr_ok | output | 16 | Per-target qualified write strobe |
| tgt_allow | output | 16 | Per-target status: enable AND NOT lock |

## Verification
The bench builds the block with its default parameters: sixteen targets, a 16-bit address and the control offset 0x1E80. With these values every enable/lock pair can be driven, so a vector can lock some targets while it rewrites the enables of others. The bench then checks that an enable write aimed at a locked target is refused. It also writes to a neighbouring address to show that no write lands outside the control word, and it resets again to show that the lock bits are released.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Next lock value: sticky set, no software clear.
  function automatic logic [15:0] f_next_lock(input logic [15:0] lock_old,
                                              input logic [15:0] wr_bits);
    f_next_lock = lock_old | wr_bits;
  endfunction

  // Next enable value: take written bit only where the target is unlocked.
  function automatic logic [15:0] f_next_en(input logic [15:0] en_old,
                                            input logic [15:0] lock_old,
                                            input logic [15:0] wr_bits);
    f_next_en = (en_old & lock_old) | (wr_bits & ~lock_old);
  endfunction

  // Write permission for one target.
  function automatic logic f_allow(input logic en, input logic lock);
    f_allow = en & ~lock;
  endfunction

endpackage

// File: rtl/wp_bus_decode.sv
module wp_bus_decode #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h1E80
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] ctrl_word,
  output logic              ctrl_hit,
  output logic              ctrl_wr,
  output logic [DATA_W-1:0] bus_rdata
);

  always_comb begin
    ctrl_hit  = (bus_addr == CTRL_ADDR);
    ctrl_wr   = ctrl_hit & bus_we;
    bus_rdata = ctrl_hit ? ctrl_word : '0;
  end

endmodule

// File: rtl/wp_ctrl_reg.sv
module wp_ctrl_reg
  import wp_pkg::*;
#(
  parameter int NUM_TGT = 16,
  localparam int DATA_W = 2 * NUM_TGT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic               other_wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_TGT-1:0] en_q,
  output logic [NUM_TGT-1:0] lock_q
);

  logic [NUM_TGT-1:0] en_nxt;
  logic [NUM_TGT-1:0] lock_nxt;

  always_comb begin
    lock_nxt = f_next_lock(lock_q, wdata[NUM_TGT-1:0]);
    en_nxt   = f_next_en(en_q, lock_q, wdata[DATA_W-1:NUM_TGT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '1;
      lock_q <= '0;
    end else if (ctrl_wr) begin
      en_q   <= en_nxt;
      lock_q <= lock_nxt;
    end
  end

  // R3: a set lock bit never drops while out of reset
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R4: an enable bit whose lock was already set cannot move
  p_en_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((en_q ^ $past(en_q)) & $past(lock_q)) == '0));

  // R7: a write to another address leaves the word alone
  p_other_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> ($stable(en_q) && $stable(lock_q)));

endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_pkg::*;
#(
  parameter int NUM_TGT = 16
) (
  input  logic [NUM_TGT-1:0] en_q,
  input  logic [NUM_TGT-1:0] lock_q,
  input  logic [NUM_TGT-1:0] wr_req,
  output logic [NUM_TGT-1:0] wr_ok,
  output logic [NUM_TGT-1:0] allow
);

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    always_comb begin
      allow[g] = f_allow(en_q[g], lock_q[g]);
      wr_ok[g] = wr_req[g] & allow[g];
    end
  end

endmodule

// File: rtl/wr_protect_ctrl.sv
module wr_protect_ctrl #(
  parameter int NUM_TGT = 16,
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h1E80,
  localparam int DATA_W = 2 * NUM_TGT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_TGT-1:0] tgt_wr_req,
  output logic [NUM_TGT-1:0] tgt_wr_ok,
  output logic [NUM_TGT-1:0] tgt_allow
);

  logic [NUM_TGT-1:0] en_q;
  logic [NUM_TGT-1:0] lock_q;
  logic [DATA_W-1:0]  ctrl_word;
  logic               ctrl_hit;
  logic               ctrl_wr;
  logic               other_wr;

  assign ctrl_word = {en_q, lock_q};
  assign other_wr  = bus_we & ~ctrl_hit;

  wp_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .ctrl_word(ctrl_word),
    .ctrl_hit (ctrl_hit),
    .ctrl_wr  (ctrl_wr),
    .bus_rdata(bus_rdata)
  );

  wp_ctrl_reg #(.NUM_TGT(NUM_TGT)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .other_wr(other_wr),
    .wdata   (bus_wdata),
    .en_q    (en_q),
    .lock_q  (lock_q)
  );

  wp_gate #(.NUM_TGT(NUM_TGT)) u_gate (
    .en_q  (en_q),
    .lock_q(lock_q),
    .wr_req(tgt_wr_req),
    .wr_ok (tgt_wr_ok),
    .allow (tgt_allow)
  );

  // R5: no strobe leaves without a request behind it
  p_ok_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_wr_ok & ~tgt_wr_req) == '0));

  // R5: a locked target never receives a strobe
  p_locked_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_wr_ok & lock_q) == '0));

  // R6: status never claims a locked target is open
  p_allow_vs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_allow & lock_q) == '0));

endmodule

// File: tb/tb_wr_protect_ctrl.sv
module tb_wr_protect_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CTRL = 16'h1E80;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tgt_wr_req = '0;
  logic [15:0] tgt_wr_ok;
  logic [15:0] tgt_allow;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_protect_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_wr_req(tgt_wr_req),
    .tgt_wr_ok(tgt_wr_ok), .tgt_allow(tgt_allow)
  );

  // {write data, expected control word, expected allow}
  localparam int NV = 7;
  localparam logic [79:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 16'h0000},
    {32'hA5A5_0000, 32'hA5A5_0000, 16'hA5A5},
    {32'h0F0F_00F0, 32'h0F0F_00F0, 16'h0F0F},
    {32'hFFFF_0000, 32'hFF0F_00F0, 16'hFF0F},
    {32'h0000_0F00, 32'h0000_0FF0, 16'h0000},
    {32'hFFFF_0000, 32'hF00F_0FF0, 16'hF00F},
    {32'h0000_0000, 32'h0000_0FF0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = CTRL;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bus_addr = CTRL;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 reset word", bus_rdata, 32'hFFFF_0000);
    chk("R6 reset allow", {16'h0, tgt_allow}, 32'h0000_FFFF);
    tgt_wr_req = 16'h5A5A; #1;
    chk("R5 reset pass-through", {16'h0, tgt_wr_ok}, 32'h0000_5A5A);
    // R2 other address reads zero, no side effect
    bus_addr = 16'h1E84; #1;
    chk("R2 other addr read", bus_rdata, 32'h0);
    bus_addr = CTRL; #1;
    chk("R2 read no side effect", bus_rdata, 32'hFFFF_0000);
    // R7 write elsewhere ignored
    wr(16'h1E84, 32'h0000_FFFF);
    chk("R7 other addr write", bus_rdata, 32'hFFFF_0000);
    chk("R7 allow unchanged", {16'h0, tgt_allow}, 32'h0000_FFFF);

    // table walk: R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      wr(CTRL, VEC[i][79:48]);
      chk("R8 R3 R4 word after write", bus_rdata, VEC[i][47:16]);
      chk("R6 allow", {16'h0, tgt_allow}, {16'h0, VEC[i][15:0]});
      tgt_wr_req = 16'hFFFF; #1;
      chk("R5 all requests", {16'h0, tgt_wr_ok}, {16'h0, VEC[i][15:0]});
      tgt_wr_req = 16'h3C3C; #1;
      chk("R5 partial requests", {16'h0, tgt_wr_ok}, {16'h0, VEC[i][15:0] & 16'h3C3C});
    end

    // R3 writing zero keeps locks; R8 not visible before the edge
    @(negedge clk);
    bus_addr = CTRL; bus_we = 1; bus_wdata = 32'hFFFF_FFFF; #1;
    chk("R8 before edge", bus_rdata, 32'h0000_0FF0);
    @(negedge clk); bus_we = 0; #1;
    chk("R3 R4 lock all", bus_rdata, 32'hF00F_FFFF);
    chk("R6 all locked", {16'h0, tgt_allow}, 32'h0);
    wr(CTRL, 32'h0000_0000);
    chk("R3 locks stay", bus_rdata, 32'hF00F_FFFF);

    // R1 R3 reset releases locks
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    chk("R1 R3 reset clears lock", bus_rdata, 32'hFFFF_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule